// File: doc/BRIEF.md
# Modulator Serial Bitstream Receiver

This block is the front end of one receive channel behind an external sigma-delta modulator. It turns the modulator's 1-bit stream into a data bit and a one-cycle valid strobe per recovered bit, in the system clock domain. Two line formats are handled. In clocked serial capture, a data pin is strobed by a clock pin on a chosen edge. In Manchester mode, the data pin alone carries both the clock and the data.

The strobe clock can come from the channel's external clock pin or from the chip's generated output clock. The output clock can be used on every edge of the chosen polarity, or on every second edge, for modulators that halve their clock before returning data. The pins can be taken from this channel's own lane or from the next lane, wrapping at the last one. One write port carries the enable bit and the format, clock and lane fields. The format, clock and lane fields are frozen while the channel runs.

In Manchester mode, the decoder learns the half-bit time from the shortest gap between line transitions. It then separates mid-bit transitions, which carry data, from boundary transitions.

Top module: `sd_bitstream_rx`

## Requirements
- R1: After reset the channel is disabled with all fields zero, and `bit_o` and `bit_valid_o` are low.
- R2: While the enable bit is 0, `bit_valid_o` stays low whatever the pins do.
- R3: With clock select 0 (clock pin) or 1 (output clock), format 0 samples the data pin on every rising clock edge and format 1 on every falling edge. Each sample yields one valid strobe carrying the sampled level.
- R4: Clock select 2 samples on every second falling edge of the output clock, and clock select 3 on every second rising edge. Edges are counted from enable, so the first sample is taken on the second edge.
- R5: Format 2 decodes a rising mid-bit transition as 0 and a falling one as 1. Format 3 uses the opposite mapping.
- R6: In Manchester mode the decoder takes the shortest gap seen between transitions since enable as half a bit. It emits its first bit at the first transition whose gap exceeds 1.5 times that value. After that it emits one bit per transition that lies more than 1.5 half-bits after the previous data transition, and boundary transitions emit nothing.
- R7: Lane select 0 takes the clock and data pins of lane `CH_IDX`. Lane select 1 takes lane `(CH_IDX+1) mod NUM_CH`.
- R8: A write made while the channel is enabled changes only the enable bit. The format, clock select and lane select keep their previous values.
- R9: `bit_valid_o` is never high for two cycles in a row, and each received bit produces exactly one strobe. While the channel stays enabled, `bit_o` changes only together with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ckin_i | input | NUM_CH | Serial clock pins, one per lane |
| datin_i | input | NUM_CH | Serial data pins, one per lane |
| ckout_i | input | 1 | Generated output clock, synchronous to clk_i |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_chen_i | input | 1 | Channel enable value to write |
| cfg_itype_i | input | 2 | Line format: 0 rising capture, 1 falling capture, 2/3 Manchester |
| cfg_cksel_i | input | 2 | Clock select: 0 pin, 1 output clock, 2/3 output clock every second falling/rising edge |
| cfg_insel_i | input | 1 | Lane select: 0 own lane, 1 next lane |
| bit_o | output | 1 | Recovered bit |
| bit_valid_o | output | 1 | One-cycle strobe per recovered bit |

## Verification
The bench builds the block with `NUM_CH = 4` and `CH_IDX = 3`, so lane select 1 must wrap round to lane 0. The unselected lane carries inverted data, so a wrong lane choice shows up as a miscompare. It sweeps every capture format against every clock select and both lane choices, and runs both Manchester polarities on both lanes. A half-bit of six cycles keeps the short and long Manchester gaps clearly on either side of the 1.5 threshold. Further runs attempt a mid-stream reconfiguration and drive pins while the channel is disabled.

// File: rtl/sd_rx_pkg.sv
package sd_rx_pkg;

  typedef enum logic [1:0] {
    IT_CAP_RISE  = 2'd0,
    IT_CAP_FALL  = 2'd1,
    IT_MAN_RISE0 = 2'd2,
    IT_MAN_RISE1 = 2'd3
  } itype_e;

  typedef enum logic [1:0] {
    CK_PIN        = 2'd0,
    CK_OUT        = 2'd1,
    CK_OUT_HALF_F = 2'd2,
    CK_OUT_HALF_R = 2'd3
  } cksel_e;

  typedef struct packed {
    logic   chen;
    itype_e itype;
    cksel_e cksel;
    logic   insel;
  } cfg_t;

endpackage

// File: rtl/sd_rx_sync.sv
module sd_rx_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  localparam int unsigned CHAIN_W = STAGES * W;

  logic [CHAIN_W-1:0] chain_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= d_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[CHAIN_W-W-1:0], d_i};
    end
  end

  assign q_o = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/sd_rx_cfg.sv
module sd_rx_cfg
  import sd_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       chen_i,
  input  logic [1:0] itype_i,
  input  logic [1:0] cksel_i,
  input  logic       insel_i,
  output cfg_t       cfg_o
);

  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.chen  <= 1'b0;
      cfg_q.itype <= IT_CAP_RISE;
      cfg_q.cksel <= CK_PIN;
      cfg_q.insel <= 1'b0;
    end else if (we_i) begin
      cfg_q.chen <= chen_i;
      // format, clock and lane fields are frozen while running
      if (!cfg_q.chen) begin
        cfg_q.itype <= itype_e'(itype_i);
        cfg_q.cksel <= cksel_e'(cksel_i);
        cfg_q.insel <= insel_i;
      end
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/sd_rx_frontend.sv
module sd_rx_frontend #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned CH_IDX      = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insel_i,
  input  logic              use_pin_clk_i,
  input  logic [NUM_CH-1:0] ckin_i,
  input  logic [NUM_CH-1:0] datin_i,
  input  logic              ckout_i,
  output logic              rise_o,
  output logic              fall_o,
  output logic              dat_o,
  output logic              dat_tr_o
);

  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [IDX_W-1:0] OWN_LANE  = IDX_W'(CH_IDX);
  localparam logic [IDX_W-1:0] NEXT_LANE = IDX_W'((CH_IDX + 1) % NUM_CH);

  logic [IDX_W-1:0] lane;
  logic             ck_raw, dat_raw;
  logic             ck_s, dat_s;
  logic             ck_d_q, dat_d_q;

  assign lane    = insel_i ? NEXT_LANE : OWN_LANE;
  // internal clock goes through the same stages to stay aligned with data
  assign ck_raw  = use_pin_clk_i ? ckin_i[lane] : ckout_i;
  assign dat_raw = datin_i[lane];

  sd_rx_sync #(
    .STAGES(SYNC_STAGES),
    .W     (2)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ck_raw, dat_raw}),
    .q_o   ({ck_s, dat_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_d_q  <= 1'b0;
      dat_d_q <= 1'b0;
    end else begin
      ck_d_q  <= ck_s;
      dat_d_q <= dat_s;
    end
  end

  assign rise_o   = ck_s & ~ck_d_q;
  assign fall_o   = ~ck_s & ck_d_q;
  assign dat_o    = dat_s;
  assign dat_tr_o = dat_s ^ dat_d_q;

endmodule

// File: rtl/sd_rx_cap.sv
module sd_rx_cap (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       fall_sel_i,
  input  logic [1:0] cksel_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic       bit_o,
  output logic       vld_o
);

  logic edge_hit, halve, take;
  logic phase_q, bit_q, vld_q;

  always_comb begin
    unique case (cksel_i)
      2'd2:    edge_hit = fall_i;
      2'd3:    edge_hit = rise_i;
      default: edge_hit = fall_sel_i ? fall_i : rise_i;
    endcase
  end

  assign halve = cksel_i[1];
  assign take  = edge_hit & (~halve | phase_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      bit_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else if (!en_i) begin
      phase_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= take;
      if (edge_hit && halve) phase_q <= ~phase_q;
      if (take)              bit_q   <= dat_i;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/sd_rx_manch.sv
module sd_rx_manch #(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic inv_i,
  input  logic tr_i,
  input  logic dat_i,
  output logic bit_o,
  output logic vld_o
);

  logic [CNT_W-1:0] gap_q, since_q, min_q;
  logic             seen_q, lock_q, bit_q, vld_q;
  logic [CNT_W:0]   thr;
  logic             gap_long, since_long, data_tr;

  // 1.5 x shortest gap
  assign thr        = {1'b0, min_q} + {2'b00, min_q[CNT_W-1:1]};
  assign gap_long   = {1'b0, gap_q} > thr;
  assign since_long = {1'b0, since_q} > thr;
  assign data_tr    = tr_i & seen_q & (lock_q ? since_long : gap_long);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      since_q <= '0;
      min_q   <= '1;
      seen_q  <= 1'b0;
      lock_q  <= 1'b0;
      bit_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else if (!en_i) begin
      gap_q   <= '0;
      since_q <= '0;
      min_q   <= '1;
      seen_q  <= 1'b0;
      lock_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= data_tr;
      if (tr_i)               gap_q <= '0;
      else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
      if (tr_i)               seen_q <= 1'b1;
      if (tr_i && seen_q && (gap_q < min_q)) min_q <= gap_q;
      if (data_tr) begin
        lock_q  <= 1'b1;
        since_q <= '0;
        bit_q   <= dat_i ^ ~inv_i;
      end else if (since_q != '1) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/sd_bitstream_rx.sv
module sd_bitstream_rx
  import sd_rx_pkg::*;
#(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned CH_IDX      = 0,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] ckin_i,
  input  logic [NUM_CH-1:0] datin_i,
  input  logic              ckout_i,
  input  logic              cfg_we_i,
  input  logic              cfg_chen_i,
  input  logic [1:0]        cfg_itype_i,
  input  logic [1:0]        cfg_cksel_i,
  input  logic              cfg_insel_i,
  output logic              bit_o,
  output logic              bit_valid_o
);

  cfg_t cfg_q;
  logic rise, fall, dat_s, dat_tr;
  logic is_man, cap_en, man_en;
  logic cap_bit, cap_vld, man_bit, man_vld;

  sd_rx_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .chen_i (cfg_chen_i),
    .itype_i(cfg_itype_i),
    .cksel_i(cfg_cksel_i),
    .insel_i(cfg_insel_i),
    .cfg_o  (cfg_q)
  );

  sd_rx_frontend #(
    .NUM_CH     (NUM_CH),
    .CH_IDX     (CH_IDX),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_fe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .insel_i      (cfg_q.insel),
    .use_pin_clk_i(cfg_q.cksel == CK_PIN),
    .ckin_i       (ckin_i),
    .datin_i      (datin_i),
    .ckout_i      (ckout_i),
    .rise_o       (rise),
    .fall_o       (fall),
    .dat_o        (dat_s),
    .dat_tr_o     (dat_tr)
  );

  assign is_man = cfg_q.itype[1];
  assign cap_en = cfg_q.chen & ~is_man;
  assign man_en = cfg_q.chen & is_man;

  sd_rx_cap u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cap_en),
    .fall_sel_i(cfg_q.itype[0]),
    .cksel_i   (cfg_q.cksel),
    .rise_i    (rise),
    .fall_i    (fall),
    .dat_i     (dat_s),
    .bit_o     (cap_bit),
    .vld_o     (cap_vld)
  );

  sd_rx_manch #(
    .CNT_W(CNT_W)
  ) u_man (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (man_en),
    .inv_i (cfg_q.itype[0]),
    .tr_i  (dat_tr),
    .dat_i (dat_s),
    .bit_o (man_bit),
    .vld_o (man_vld)
  );

  assign bit_o       = is_man ? man_bit : cap_bit;
  assign bit_valid_o = is_man ? man_vld : cap_vld;

endmodule

// File: rtl/sd_rx_chk.sv
module sd_rx_chk
  import sd_rx_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input cfg_t cfg_i,
  input logic bit_i,
  input logic vld_i
);

  // R8
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_i.chen) |-> $stable({cfg_i.itype, cfg_i.cksel, cfg_i.insel}));

  // R2
  no_strobe_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |-> $past(cfg_i.chen));

  // R9
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> !vld_i);

  // R9
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.chen && $past(cfg_i.chen) && !vld_i) |-> $stable(bit_i));

endmodule

bind sd_bitstream_rx sd_rx_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cfg_i (cfg_q),
  .bit_i (bit_o),
  .vld_i (bit_valid_o)
);

// File: tb/tb_sd_bitstream_rx.sv
module tb_sd_bitstream_rx;

  localparam int NUM_CH = 4;
  localparam int CH_IDX = 3;
  localparam int H      = 6;
  localparam int NB     = 20;
  localparam int RX_MAX = 4096;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NUM_CH-1:0] ckin = '0;
  logic [NUM_CH-1:0] datin = '0;
  logic              ckout = 1'b0;
  logic              we = 1'b0, chen = 1'b0, insel = 1'b0;
  logic [1:0]        itype = 2'd0, cksel = 2'd0;
  logic              bit_o, bit_valid_o;

  always #4 clk_i = ~clk_i;

  sd_bitstream_rx #(
    .NUM_CH(NUM_CH),
    .CH_IDX(CH_IDX)
  ) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ckin_i     (ckin),
    .datin_i    (datin),
    .ckout_i    (ckout),
    .cfg_we_i   (we),
    .cfg_chen_i (chen),
    .cfg_itype_i(itype),
    .cfg_cksel_i(cksel),
    .cfg_insel_i(insel),
    .bit_o      (bit_o),
    .bit_valid_o(bit_valid_o)
  );

  int   n_vec = 0, n_fail = 0;
  logic rx_bits [RX_MAX];
  int   rx_n = 0;
  logic exp_bits [64];
  int   exp_n;
  logic [15:0] lfsr = 16'hACE1;
  int   cur_sel, cur_oth;
  logic cur_pin;

  always @(negedge clk_i) begin
    if (rst_ni && bit_valid_o) begin
      if (rx_n < RX_MAX) rx_bits[rx_n] = bit_o;
      rx_n++;
    end
  end

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic cfg_wr(input logic c, input logic [1:0] it, input logic [1:0] cs,
                        input logic ins);
    @(negedge clk_i);
    we = 1'b1; chen = c; itype = it; cksel = cs; insel = ins;
    @(negedge clk_i);
    we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pick_lane(input logic ins);
    cur_sel = ins ? (CH_IDX + 1) % NUM_CH : CH_IDX;
    cur_oth = ins ? CH_IDX : (CH_IDX + 1) % NUM_CH;
  endtask

  task automatic set_pins(input logic ck, input logic d);
    if (cur_pin) begin
      ckin[cur_sel] = ck;
      ckin[cur_oth] = ck;
    end else begin
      ckout = ck;
    end
    datin[cur_sel] = d;
    datin[cur_oth] = ~d;
  endtask

  task automatic compare(input int base, input string req_bits, input string req_cnt);
    chk(rx_n - base == exp_n, req_cnt, "strobe count", rx_n - base, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      if (base + i < rx_n && base + i < RX_MAX)
        chk(rx_bits[base + i] == exp_bits[i], req_bits, $sformatf("bit %0d", i),
            int'(rx_bits[base + i]), int'(exp_bits[i]));
    end
  endtask

  task automatic run_cap(input int it, input int cs, input logic ins, input logic poke);
    logic idle;
    int   base;
    string rq;
    pick_lane(ins);
    cur_pin = (cs == 0);
    idle    = (cs == 2) ? 1'b0 : (cs == 3) ? 1'b1 : it[0];
    ckin    = {NUM_CH{idle}};
    ckout   = idle;
    set_pins(idle, 1'b0);
    cfg_wr(1'b0, 2'(it), 2'(cs), ins);
    wait_cyc(6);
    cfg_wr(1'b1, 2'(it), 2'(cs), ins);
    wait_cyc(4);
    base  = rx_n;
    exp_n = NB;
    for (int b = 0; b < NB; b++) begin
      logic v;
      v = next_bit();
      exp_bits[b] = v;
      if (cs < 2) begin
        set_pins(idle, v);  wait_cyc(H);
        set_pins(~idle, v); wait_cyc(H);
      end else begin
        set_pins(~idle, v); wait_cyc(H);
        set_pins(idle, v);  wait_cyc(H);
        set_pins(~idle, v); wait_cyc(H);
        set_pins(idle, v);  wait_cyc(H);
      end
      if (poke && b == NB / 2) begin
        set_pins(idle, v);
        // R8: attempted reconfiguration while running
        cfg_wr(1'b1, 2'(it ^ 1), 2'd2, ~ins);
      end
    end
    set_pins(idle, exp_bits[NB-1]);
    wait_cyc(8);
    cfg_wr(1'b0, 2'(it), 2'(cs), ins);
    wait_cyc(4);
    rq = poke ? "R8" : ins ? "R7" : (cs < 2) ? "R3" : "R4";
    compare(base, rq, "R9");
    if (poke) begin
      // R8: enable bit still writable, channel now silent
      base = rx_n;
      for (int k = 0; k < 8; k++) begin
        set_pins(~idle, k[0]); wait_cyc(H);
        set_pins(idle, k[0]);  wait_cyc(H);
      end
      chk(rx_n == base, "R8", "strobes after disable", rx_n - base, 0);
    end
  endtask

  task automatic run_man(input int it, input int cs, input logic ins);
    logic first;
    int   base;
    pick_lane(ins);
    cur_pin = 1'b0;
    exp_n = 0;
    for (int b = 0; b < NB; b++) begin
      logic v;
      v = (b < 3) ? 1'b0 : (b == 3) ? 1'b1 : next_bit();
      exp_bits[b] = v;
    end
    first = exp_bits[0] ^ (it == 3);
    set_pins(ckout, first);
    cfg_wr(1'b0, 2'(it), 2'(cs), ins);
    wait_cyc(6);
    cfg_wr(1'b1, 2'(it), 2'(cs), ins);
    wait_cyc(4);
    base = rx_n;
    for (int b = 0; b < NB; b++) begin
      first = exp_bits[b] ^ (it == 3);
      set_pins(ckout, first);  wait_cyc(H);
      set_pins(ckout, ~first); wait_cyc(H);
    end
    wait_cyc(3 * H);
    cfg_wr(1'b0, 2'(it), 2'(cs), ins);
    wait_cyc(4);
    // R6: lock on bit 3, the first long gap after a short one
    for (int i = 0; i < NB - 3; i++) exp_bits[i] = exp_bits[i + 3];
    exp_n = NB - 3;
    compare(base, ins ? "R7" : "R5", "R6");
  endtask

  initial begin
    wait_cyc(3);
    // R1: outputs held low in reset
    chk(bit_valid_o == 1'b0, "R1", "valid in reset", int'(bit_valid_o), 0);
    chk(bit_o == 1'b0, "R1", "bit in reset", int'(bit_o), 0);
    rst_ni = 1'b1;
    wait_cyc(2);
    chk(bit_valid_o == 1'b0 && bit_o == 1'b0, "R1", "outputs after reset",
        int'({bit_valid_o, bit_o}), 0);
    // R2: disabled channel ignores pin activity
    for (int k = 0; k < 16; k++) begin
      ckin = ~ckin; ckout = ~ckout; datin = k[0] ? '1 : '0;
      wait_cyc(3);
    end
    chk(rx_n == 0, "R2", "strobes while disabled", rx_n, 0);
    for (int it = 0; it < 2; it++)
      for (int cs = 0; cs < 4; cs++)
        for (int ins = 0; ins < 2; ins++)
          run_cap(it, cs, ins[0], 1'b0);
    for (int it = 2; it < 4; it++)
      for (int ins = 0; ins < 2; ins++) begin
        run_man(it, 0, ins[0]);
        run_man(it, 3, ins[0]);
      end
    run_cap(0, 0, 1'b0, 1'b1);
    run_cap(1, 3, 1'b1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_vec++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule